// File: doc/BRIEF.md
# Dual-Channel Overcurrent Latch-Off Controller

This block is the digital control for a pair of protected power switches. Each channel has an enable request and an overcurrent indication from an analog sense circuit. For each channel it drives a switch-on command, a shutdown-speed select, a regulation-active flag and a fault pull-down request. A shared supply-good flag and a shared over-temperature flag act on both channels.

When overcurrent appears on a running channel, the channel enters regulation and a per-channel cycle counter starts. If the overcurrent is still present when the counter reaches its limit, the switch is latched off and the fault is raised. The fault stays up until that channel's enable is withdrawn. For a fixed number of cycles after each turn-on, fault reporting is held back. The two channels share no state. Each enable and overcurrent input passes through a two-stage synchroniser, and every output is registered.

Top module: `ocl_dual_ctrl`

## Requirements
- R1: Once a channel is in regulation (`reg_active`=1), overcurrent held for TRIP_CYCLES consecutive clocks latches it off. On that edge `sw_on` and `reg_active` go to 0 and, if blanking is over, `fault_pull` goes to 1. An overcurrent pulse of L input cycles latches only when L > TRIP_CYCLES.
- R2: A raised `fault_pull` stays at 1 until that channel's enable is deasserted. It then returns to 0 on the third clock edge after the enable input changes.
- R3: While the channel stays latched with enable asserted and supply good, `fault_pull` stays at 1 on every cycle, whether or not the overcurrent persists.
- R4: A channel that latches before BLANK_CYCLES clocks have passed since `sw_on` rose keeps `fault_pull` at 0 until exactly BLANK_CYCLES clocks after that rise.
- R5: While `uv_ok`=0, every `sw_on` and every `fault_pull` is 0 from the next edge on, latched faults are discarded, and no channel turns on.
- R6: `fast_off`=0 selects the slow ramp and `fast_off`=1 selects the fast pulldown. Disabling from normal conduction gives 0. Disabling during regulation, or after a latch-off, gives 1.
- R7: Activity on one channel (regulation, latch-off, fault) leaves the outputs of the other channel unchanged.
- R8: Parameter EN_ACTIVE_HIGH=1 treats `en_in` bit = 1 as enable. EN_ACTIVE_HIGH=0 treats bit = 0 as enable, for all channels.
- R9: `ot_flag`=1 forces every `sw_on` to 0 from the next edge. When the flag is released, conduction resumes on the next edge if the channel is still on.
- R10: If overcurrent clears before the limit, the channel leaves regulation and its counter returns to zero. Two pulses of TRIP_CYCLES each, separated by two idle cycles, do not latch.
- R11: A change on `en_in` reaches `sw_on` on the third rising edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_in | input | NUM_CH | Per-channel enable request, polarity set by EN_ACTIVE_HIGH |
| oc_in | input | NUM_CH | Per-channel overcurrent indication, 1 = over limit |
| uv_ok | input | 1 | Supply above undervoltage threshold, synchronous |
| ot_flag | input | 1 | Over-temperature indication, synchronous |
| sw_on | output | NUM_CH | Switch-on command |
| fast_off | output | NUM_CH | Shutdown select, 1 = fast pulldown, 0 = slow ramp |
| reg_active | output | NUM_CH | Channel is in current regulation |
| fault_pull | output | NUM_CH | 1 = pull the open-drain fault line low |

## Verification
The assertions assume that `uv_ok` and `ot_flag` are already synchronous to `clk`, because only the enable and overcurrent inputs pass through synchronisers. The fault-hold property also assumes that the supply stays good for the cycle under test. The stimulus changes every input one time unit after a rising edge. It keeps the supply and temperature flags steady except during the dedicated undervoltage and over-temperature steps. Overcurrent pulse lengths are swept around the limit, and the expected latch outcome comes from the pulse length alone.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
   typedef enum logic [1:0] {
      CH_OFF   = 2'd0,
      CH_ON    = 2'd1,
      CH_REG   = 2'd2,
      CH_LATCH = 2'd3
   } ch_state_e;
endpackage

// File: rtl/ocl_sync.sv
module ocl_sync #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] meta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta <= '0;
         q    <= '0;
      end else begin
         meta <= d;
         q    <= meta;
      end
   end
endmodule

// File: rtl/ocl_channel.sv
module ocl_channel
   import ocl_pkg::*;
#(
   parameter int TRIP_CYCLES  = 16,
   parameter int BLANK_CYCLES = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic oc,
   input  logic uv_ok,
   input  logic ot_flag,
   output logic sw_on,
   output logic fast_off,
   output logic reg_active,
   output logic fault_pull
);
   localparam int TMR_W = $clog2(TRIP_CYCLES + 1);
   localparam int BLK_W = $clog2(BLANK_CYCLES + 1);
   localparam logic [TMR_W-1:0] TRIP_LAST = TMR_W'(TRIP_CYCLES - 1);
   localparam logic [BLK_W-1:0] BLK_INIT  = BLK_W'(BLANK_CYCLES);

   ch_state_e        st, nxt;
   logic [TMR_W-1:0] tmr, tmr_nxt;
   logic [BLK_W-1:0] blk, blk_nxt;
   logic             fast_nxt;

   always_comb begin
      nxt = st;
      if (!uv_ok) begin
         nxt = CH_OFF;
      end else begin
         unique case (st)
            CH_OFF:   if (en) nxt = CH_ON;
            CH_ON:    if (!en) nxt = CH_OFF; else if (oc) nxt = CH_REG;
            CH_REG:   if (!en) nxt = CH_OFF;
                      else if (!oc) nxt = CH_ON;
                      else if (tmr == TRIP_LAST) nxt = CH_LATCH;
            CH_LATCH: if (!en) nxt = CH_OFF;
            default:  nxt = CH_OFF;
         endcase
      end
   end

   always_comb begin
      tmr_nxt = (st == CH_REG && nxt == CH_REG) ? tmr + 1'b1 : '0;
      if (st == CH_OFF && nxt == CH_ON)  blk_nxt = BLK_INIT;
      else if (nxt == CH_OFF)            blk_nxt = '0;
      else if (blk != '0)                blk_nxt = blk - 1'b1;
      else                               blk_nxt = '0;
      fast_nxt = fast_off;
      if (!uv_ok)                              fast_nxt = 1'b1;
      else if (nxt == CH_LATCH)                fast_nxt = 1'b1;
      else if (st == CH_REG && nxt == CH_OFF)  fast_nxt = 1'b1;
      else if (st == CH_ON && nxt == CH_OFF)   fast_nxt = 1'b0;
      else if (st == CH_OFF && nxt == CH_ON)   fast_nxt = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= CH_OFF;
         tmr        <= '0;
         blk        <= '0;
         sw_on      <= 1'b0;
         fast_off   <= 1'b0;
         reg_active <= 1'b0;
         fault_pull <= 1'b0;
      end else begin
         st         <= nxt;
         tmr        <= tmr_nxt;
         blk        <= blk_nxt;
         sw_on      <= uv_ok && !ot_flag && (nxt == CH_ON || nxt == CH_REG);
         fast_off   <= fast_nxt;
         reg_active <= (nxt == CH_REG);
         fault_pull <= (nxt == CH_LATCH) && (blk_nxt == '0);
      end
   end

   AST_FAULT_SW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pull |-> (!sw_on && !reg_active));                          // R1
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_pull && en && uv_ok) |=> fault_pull);                      // R3
   AST_UV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !uv_ok |=> (!fault_pull && !sw_on));                              // R5
   AST_FAULT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pull |-> fast_off);                                         // R6
   AST_OT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ot_flag |=> !sw_on);                                              // R9
endmodule

// File: rtl/ocl_dual_ctrl.sv
module ocl_dual_ctrl #(
   parameter int NUM_CH         = 2,
   parameter int TRIP_CYCLES    = 16,
   parameter int BLANK_CYCLES   = 24,
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] en_in,
   input  logic [NUM_CH-1:0] oc_in,
   input  logic              uv_ok,
   input  logic              ot_flag,
   output logic [NUM_CH-1:0] sw_on,
   output logic [NUM_CH-1:0] fast_off,
   output logic [NUM_CH-1:0] reg_active,
   output logic [NUM_CH-1:0] fault_pull
);
   localparam int SYNC_W = 2 * NUM_CH;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (TRIP_CYCLES < 2) begin : g_bad_trip
      $error("TRIP_CYCLES must be at least 2");
   end
   if (BLANK_CYCLES < 1) begin : g_bad_blank
      $error("BLANK_CYCLES must be at least 1");
   end

   logic [NUM_CH-1:0] en_true, en_s, oc_s;

   if (EN_ACTIVE_HIGH) begin : g_en_hi
      assign en_true = en_in;
   end else begin : g_en_lo
      assign en_true = ~en_in;
   end

   ocl_sync #(.WIDTH(SYNC_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({oc_in, en_true}),
      .q     ({oc_s, en_s})
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ocl_channel #(
         .TRIP_CYCLES  (TRIP_CYCLES),
         .BLANK_CYCLES (BLANK_CYCLES)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (en_s[c]),
         .oc         (oc_s[c]),
         .uv_ok      (uv_ok),
         .ot_flag    (ot_flag),
         .sw_on      (sw_on[c]),
         .fast_off   (fast_off[c]),
         .reg_active (reg_active[c]),
         .fault_pull (fault_pull[c])
      );
   end
endmodule

// File: tb/test_ocl_dual_ctrl.sv
module test_ocl_dual_ctrl;
   localparam int TRIP  = 16;
   localparam int BLANK = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] en_in = 2'b00, oc_in = 2'b00;
   logic [1:0] en_n = 2'b11, oc_lo = 2'b00;
   logic       uv_ok = 1'b1, ot_flag = 1'b0;
   logic [1:0] sw_on, fast_off, reg_active, fault_pull;
   logic [1:0] sw_lo, fast_lo, reg_lo, fault_lo;
   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz, period 8 units

   ocl_dual_ctrl #(.NUM_CH(2), .TRIP_CYCLES(TRIP), .BLANK_CYCLES(BLANK),
                   .EN_ACTIVE_HIGH(1'b1)) i_ocl_dual_ctrl (
      .clk(clk), .rst_n(rst_n), .en_in(en_in), .oc_in(oc_in), .uv_ok(uv_ok),
      .ot_flag(ot_flag), .sw_on(sw_on), .fast_off(fast_off),
      .reg_active(reg_active), .fault_pull(fault_pull));

   ocl_dual_ctrl #(.NUM_CH(2), .TRIP_CYCLES(TRIP), .BLANK_CYCLES(BLANK),
                   .EN_ACTIVE_HIGH(1'b0)) i_ocl_dual_ctrl_lo (
      .clk(clk), .rst_n(rst_n), .en_in(en_n), .oc_in(oc_lo), .uv_ok(uv_ok),
      .ot_flag(ot_flag), .sw_on(sw_lo), .fast_off(fast_lo),
      .reg_active(reg_lo), .fault_pull(fault_lo));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #1600000;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(3);
      chk("reset sw_on", sw_on, 0);
      chk("reset fault_pull", fault_pull, 0);
      chk("reset fast_off", fast_off, 0);
      rst_n = 1'b1;
      tick(2);

      // R8: active-low instance
      chk("R8 lo idle", sw_lo, 0);
      en_n = 2'b00;
      tick(3);
      chk("R8 lo enabled", sw_lo, 3);
      en_n = 2'b11;

      // R5: no turn-on while supply is low
      uv_ok = 1'b0; en_in = 2'b10;
      tick(6);
      chk("R5 no turn-on", sw_on, 0);
      uv_ok = 1'b1;
      tick(4);
      chk("R5 turn-on after supply good", sw_on[1], 1);

      // R11 + R4 + R1: channel 0 turned on into a standing overcurrent
      oc_in[0] = 1'b1;
      tick(3);
      en_in[0] = 1'b1;
      tick(2);
      chk("R11 before third edge", sw_on[0], 0);
      tick(1);                              // edge T
      chk("R11 third edge", sw_on[0], 1);
      tick(16);
      chk("R1 still conducting at T+16", sw_on[0], 1);
      chk("R1 regulating at T+16", reg_active[0], 1);
      tick(1);
      chk("R1 latched off at T+17", sw_on[0], 0);
      chk("R1 regulation ended", reg_active[0], 0);
      chk("R4 fault blanked at T+17", fault_pull[0], 0);
      chk("R6 fast after latch", fast_off[0], 1);
      tick(6);
      chk("R4 fault blanked at T+23", fault_pull[0], 0);
      tick(1);
      chk("R4 fault at T+24", fault_pull[0], 1);

      // R3 + R7: fault steady, other channel untouched
      for (int i = 0; i < 40; i++) begin
         if (i == 20) oc_in[0] = 1'b0;
         tick(1);
         chk("R3 fault steady", fault_pull[0], 1);
         chk("R7 other channel on", sw_on[1], 1);
         chk("R7 other channel no fault", fault_pull[1], 0);
      end

      // R2: clears only when enable removed
      en_in[0] = 1'b0;
      tick(2);
      chk("R2 fault before third edge", fault_pull[0], 1);
      tick(1);
      chk("R2 fault cleared", fault_pull[0], 0);
      chk("R6 fast kept after clear", fast_off[0], 1);

      // R6: slow ramp from normal conduction
      en_in[0] = 1'b1;
      tick(40);
      chk("R6 on before slow off", sw_on[0], 1);
      en_in[0] = 1'b0;
      tick(3);
      chk("R6 off", sw_on[0], 0);
      chk("R6 slow ramp", fast_off[0], 0);

      // R6: fast pulldown when disabled in regulation
      en_in[0] = 1'b1;
      tick(40);
      oc_in[0] = 1'b1;
      tick(5);
      chk("R6 regulating", reg_active[0], 1);
      en_in[0] = 1'b0;
      tick(3);
      chk("R6 fast from regulation", fast_off[0], 1);
      chk("R6 off from regulation", sw_on[0], 0);
      oc_in[0] = 1'b0;

      // R9: over-temperature
      en_in[0] = 1'b1;
      tick(40);
      ot_flag = 1'b1;
      tick(1);
      chk("R9 forced off", sw_on, 0);
      ot_flag = 1'b0;
      tick(1);
      chk("R9 resumed", sw_on, 3);

      // R5: supply loss drops a latched fault
      oc_in[0] = 1'b1;
      tick(40);
      chk("R5 precondition fault", fault_pull[0], 1);
      uv_ok = 1'b0;
      tick(1);
      chk("R5 fault discarded", fault_pull, 0);
      chk("R5 outputs off", sw_on, 0);
      oc_in[0] = 1'b0;
      tick(10);
      chk("R5 held off", sw_on, 0);
      uv_ok = 1'b1;
      tick(2);
      chk("R5 back on", sw_on, 3);
      tick(BLANK + 4);

      // R1 + R10: sweep pulse length around the limit
      for (int len = 1; len <= TRIP + 3; len++) begin
         oc_in[0] = 1'b1;
         tick(len);
         oc_in[0] = 1'b0;
         tick(6);
         chk($sformatf("R1 R10 pulse %0d fault", len), fault_pull[0],
             (len > TRIP) ? 1 : 0);
         chk($sformatf("R1 R10 pulse %0d sw_on", len), sw_on[0],
             (len > TRIP) ? 0 : 1);
         chk("R7 sweep other channel", sw_on[1], 1);
         en_in[0] = 1'b0;
         tick(4);
         en_in[0] = 1'b1;
         tick(BLANK + 4);
      end

      // R10: two sub-limit pulses with a short gap
      oc_in[0] = 1'b1;
      tick(TRIP);
      oc_in[0] = 1'b0;
      tick(2);
      oc_in[0] = 1'b1;
      tick(TRIP);
      oc_in[0] = 1'b0;
      tick(6);
      chk("R10 restart no latch", fault_pull[0], 0);
      chk("R10 still on", sw_on[0], 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule